// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This block sits between a bus master and a peripheral bus and gives every bit of every peripheral register a word-sized address of its own. An access to that alias word is turned into a single-bit operation on the real register. An alias read returns the chosen bit alone. An alias write changes only that bit, through an internal read-modify-write, so software can set or clear one control or status bit with a single store and no sequence of its own.

The alias window is 32 times the size of the peripheral region, and it starts at `ALIAS_BASE`. With the defaults, the peripheral region is 1 MiB at 0x40000000 and the alias window is 0x42000000 to 0x43FFFFFF. The target byte offset is the alias offset shifted right by five and rounded down to a word. Address bits [6:2] select the bit. Addresses outside the window pass to the peripheral bus unchanged. For example, alias 0x42008398 reaches bit 6 of the word at 0x4000041C.

The upstream side is a valid/ready request with a one-cycle response pulse. The downstream side is a request that is held until the peripheral acknowledges it. Read data arrives with the acknowledge.

Top module: `bitband_bridge`

## Requirements
- R1: A request whose address is outside the alias window produces exactly one downstream transaction with the same address, direction and write data. For a read, its response returns the peripheral data unchanged.
- R2: For an alias address A, the downstream word address is PERIPH_BASE + (((A - ALIAS_BASE) >> 5) with the low two bits cleared). No downstream request ever carries an alias-window address.
- R3: The bit operated on is A[6:2]. Each step of 4 in the alias address moves one bit higher in the same word.
- R4: An alias read makes one downstream read and no write. Its response carries the selected bit in bit 0 and zeros in bits 31:1.
- R5: An alias write makes one downstream read and then one write to the same word. That write sets the selected bit to bit 0 of the write data and leaves every other bit of the word as read. Bits 31:1 of the write data have no effect.
- R6: From the acceptance of a request until its response, up_ready is low. This makes the internal read and write of an alias write an atomic pair. A downstream request keeps its address, direction and data stable until it is acknowledged.
- R7: Each accepted request yields exactly one single-cycle resp_valid pulse. Write responses carry zero data.
- R8: During and after reset, up_ready is high, per_req is low and resp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Bridge can accept a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Byte address, word aligned |
| up_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 32 | Response data |
| per_req | output | 1 | Downstream request, held until acknowledged |
| per_write | output | 1 | Downstream direction |
| per_addr | output | 32 | Downstream word address |
| per_wdata | output | 32 | Downstream write data |
| per_ack | input | 1 | Peripheral completes the current request |
| per_rdata | input | 32 | Peripheral read data, valid with per_ack |

## Verification
The assertions assume that the peripheral raises per_ack only while per_req is high, and that it presents read data in the same cycle as the acknowledge. They also assume that upstream addresses are word aligned. The bench's peripheral stub acknowledges one cycle after each request and never otherwise. Every address the bench drives has its low two bits at zero. The bench waits for each response before it issues the next request, so the bridge is never offered a request while busy except where the atomicity check looks for it.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS_BASE  = 32'h4200_0000,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter int          REGION_LOG2 = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_valid,
  output logic        up_ready,
  input  logic        up_write,
  input  logic [31:0] up_addr,
  input  logic [31:0] up_wdata,
  output logic        resp_valid,
  output logic [31:0] resp_rdata,
  output logic        per_req,
  output logic        per_write,
  output logic [31:0] per_addr,
  output logic [31:0] per_wdata,
  input  logic        per_ack,
  input  logic [31:0] per_rdata
);
  localparam int WIN_LOG2 = REGION_LOG2 + 5;

  typedef enum logic [1:0] {S_IDLE, S_PASS, S_RBIT, S_WBIT} st_t;
  st_t st;

  logic        r_write;
  logic [31:0] r_addr, r_wdata;
  logic [4:0]  r_bit;

  wire         hit    = up_addr[31:WIN_LOG2] == ALIAS_BASE[31:WIN_LOG2];
  wire  [31:0] tgt    = PERIPH_BASE + 32'({up_addr[WIN_LOG2-1:7], 2'b00});
  wire  [31:0] sel    = 32'd1 << r_bit;
  wire  [31:0] merged = (per_rdata & ~sel) | (r_wdata[0] ? sel : 32'd0);

  assign up_ready  = st == S_IDLE;
  assign per_req   = st != S_IDLE;
  assign per_write = (st == S_WBIT) || (st == S_PASS && r_write);
  assign per_addr  = r_addr;
  assign per_wdata = r_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (up_valid) begin
          r_write <= up_write;
          r_wdata <= up_wdata;
          r_bit   <= up_addr[6:2];
          r_addr  <= hit ? tgt : up_addr;
          st      <= hit ? S_RBIT : S_PASS;
        end
        S_PASS: if (per_ack) begin
          resp_valid <= 1'b1;
          resp_rdata <= r_write ? 32'd0 : per_rdata;
          st         <= S_IDLE;
        end
        S_RBIT: if (per_ack) begin
          if (r_write) begin
            r_wdata <= merged;
            st      <= S_WBIT;
          end else begin
            resp_valid <= 1'b1;
            resp_rdata <= {31'd0, per_rdata[r_bit]};
            st         <= S_IDLE;
          end
        end
        S_WBIT: if (per_ack) begin
          resp_valid <= 1'b1;
          resp_rdata <= 32'd0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter logic [31:0] ALIAS_BASE  = 32'h4200_0000,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter int          REGION_LOG2 = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        up_valid,
  input logic        up_ready,
  input logic        up_write,
  input logic [31:0] up_addr,
  input logic [31:0] up_wdata,
  input logic        resp_valid,
  input logic [31:0] resp_rdata,
  input logic        per_req,
  input logic        per_write,
  input logic [31:0] per_addr,
  input logic [31:0] per_wdata,
  input logic        per_ack,
  input logic [31:0] per_rdata
);
  localparam int WIN_LOG2 = REGION_LOG2 + 5;
  logic was_alias_rd, was_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_alias_rd <= 1'b0;
      was_wr       <= 1'b0;
    end else if (up_valid && up_ready) begin
      was_alias_rd <= !up_write && up_addr[31:WIN_LOG2] == ALIAS_BASE[31:WIN_LOG2];
      was_wr       <= up_write;
    end
  end

  a_r8_reset_quiet: assert property (@(posedge clk) !rst_n |=> up_ready && !per_req && !resp_valid);
  a_r2_no_alias_downstream: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> per_addr[31:WIN_LOG2] != ALIAS_BASE[31:WIN_LOG2]);
  a_r6_atomic: assert property (@(posedge clk) disable iff (!rst_n) per_req |-> !up_ready);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_ack |=> per_req && $stable(per_addr) && $stable(per_write) && $stable(per_wdata));
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |=> !resp_valid);
  a_r7_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && was_wr |-> resp_rdata == 32'd0);
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && was_alias_rd |-> resp_rdata[31:1] == 31'd0);
endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ALIAS_BASE(ALIAS_BASE), .PERIPH_BASE(PERIPH_BASE), .REGION_LOG2(REGION_LOG2)
) u_chk (.*);

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic        up_ready, resp_valid, per_req, per_write;
  logic [31:0] resp_rdata, per_addr, per_wdata;
  logic        per_ack = 1'b0;
  logic [31:0] per_rdata;

  int tests = 0, fails = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] last_addr, last_wdata;
  logic [31:0] mem [16];
  logic [31:0] model [16];

  always #10 clk = ~clk;

  bitband_bridge dut (.*);

  assign per_rdata = mem[per_addr[5:2]];
  always_ff @(posedge clk) begin
    per_ack <= per_req && !per_ack;
    if (per_req && per_ack) begin
      last_addr <= per_addr;
      if (per_write) begin
        mem[per_addr[5:2]] <= per_wdata;
        last_wdata <= per_wdata;
        n_wr <= n_wr + 1;
      end else n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [31:0] a, d, output logic [31:0] r);
    int busy_ready = 0;
    @(negedge clk);
    up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = d;
    @(negedge clk);
    up_valid = 1'b0;
    while (!resp_valid) begin
      if (up_ready) busy_ready++;
      @(negedge clk);
    end
    r = resp_rdata;
    @(negedge clk);
    chk(!resp_valid, "R7 single pulse", {31'd0, resp_valid}, 32'd0);
    chk(busy_ready == 0, "R6 ready low while busy", busy_ready, 0);
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] a);
    return 32'h4000_0000 + (((a - 32'h4200_0000) >> 5) & ~32'd3);
  endfunction

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, a, w;
    int rd0, wr0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h9E37_79B1 * (i + 1);
      model[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(up_ready && !per_req && !resp_valid, "R8 reset state", {up_ready, per_req, resp_valid}, 32'b100);
    rst_n = 1'b1;

    // R1 passthrough write and read
    rd0 = n_rd; wr0 = n_wr;
    xfer(1'b1, 32'h4000_0010, 32'hCAFE_F00D, r);
    model[4] = 32'hCAFE_F00D;
    chk(mem[4] == 32'hCAFE_F00D && last_addr == 32'h4000_0010, "R1 pass write", mem[4], 32'hCAFE_F00D);
    chk(n_wr == wr0 + 1 && n_rd == rd0, "R1 pass write count", n_wr - wr0, 1);
    chk(r == 32'd0, "R7 write resp zero", r, 0);
    xfer(1'b0, 32'h4000_0010, 32'h0, r);
    chk(r == 32'hCAFE_F00D, "R1 pass read", r, 32'hCAFE_F00D);
    foreach (model[i]) ;
    // window edges pass straight through
    xfer(1'b0, 32'h41FF_FFFC, 32'h0, r);
    chk(last_addr == 32'h41FF_FFFC && r == model[15], "R1 below window", last_addr, 32'h41FF_FFFC);
    xfer(1'b0, 32'h4400_0000, 32'h0, r);
    chk(last_addr == 32'h4400_0000 && r == model[0], "R1 above window", last_addr, 32'h4400_0000);

    // R3 named example: alias 0x42008398 -> word 0x4000041C bit 6
    xfer(1'b1, 32'h4200_8398, 32'hFFFF_FFFE, r);
    model[7] = model[7] & ~32'h40;
    chk(last_addr == 32'h4000_041C, "R2 example address", last_addr, 32'h4000_041C);
    chk(mem[7] == model[7], "R3 bit 6 cleared only", mem[7], model[7]);

    // sweep words and bits
    for (int wi = 0; wi < 16; wi++) begin
      for (int b = 0; b < 32; b++) begin
        a = 32'h4200_0000 + (((32'(wi) * 4 + ((wi % 3) * 32'h100)) * 32)) + 32'(b) * 4;
        w = {31'h2AAA_5555 ^ 31'(b * 77), 1'((wi + b) % 2)};
        rd0 = n_rd; wr0 = n_wr;
        xfer(1'b1, a, w, r);
        if (w[0]) model[wi] = model[wi] | (32'd1 << b);
        else      model[wi] = model[wi] & ~(32'd1 << b);
        chk(mem[wi] == model[wi], "R5 alias write merge", mem[wi], model[wi]);
        chk(n_rd == rd0 + 1 && n_wr == wr0 + 1, "R5 read then write", n_wr - wr0, 1);
        chk(last_addr == tgt(a), "R2 target address", last_addr, tgt(a));
        rd0 = n_rd; wr0 = n_wr;
        xfer(1'b0, a, 32'h0, r);
        chk(r == {31'd0, model[wi][b]}, "R4 alias read bit0", r, {31'd0, model[wi][b]});
        chk(n_rd == rd0 + 1 && n_wr == wr0, "R4 read only", n_wr - wr0, 0);
        chk(r[0] == w[0], "R3 bit selected by addr[6:2]", r, {31'd0, w[0]});
      end
    end

    // R6 request offered while busy is not taken early
    @(negedge clk);
    up_valid = 1'b1; up_write = 1'b1; up_addr = 32'h4200_0004; up_wdata = 32'h1;
    @(negedge clk);
    up_addr = 32'h4000_0020; up_wdata = 32'h1234_5678;
    while (!resp_valid) @(negedge clk);
    up_valid = 1'b0;
    model[0] = model[0] | 32'h2;
    chk(mem[0] == model[0] && mem[8] == model[8], "R6 atomic pair intact", mem[8], model[8]);
    @(negedge clk);
    repeat (6) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule